// File: doc/BRIEF.md
# Virtual Interrupt End-of-Interrupt and Self-IPI Engine

This block holds the virtual interrupt state of one virtualized local interrupt controller. That state is a 256-bit in-service vector, a 256-bit request vector, the index of the highest in-service vector (the servicing index) and the index of the highest requested vector (the requesting index). Guest writes reach the block from two sources: a memory-mapped write with a page offset, and a model-specific-register write with a register index. Each source can carry an end-of-interrupt or a self-IPI. A load port installs a whole interrupt state at guest entry.

An end-of-interrupt retires the vector named by the servicing index. It clears that vector's in-service bit and moves the servicing index to the highest in-service bit that remains. A per-vector exit bitmap then decides the outcome: a trap-like exit that reports the retired vector, or a request to re-evaluate pending interrupts. A self-IPI posts its vector in the request vector, raises the requesting index to that vector when the vector is higher, and requests evaluation. A processor priority is derived from the task priority input and the servicing index. A deliverable flag compares the requesting index against that priority. Each operation completes in one cycle and pulses a done strobe.

Top module: `vintc_eoi_ipi`

## Requirements
- R1: While `vid_en` is 0, end-of-interrupt and self-IPI writes from either source are ignored: no done, exit or evaluate pulse, and the in-service vector, request vector, servicing index and requesting index are unchanged.
- R2: An end-of-interrupt is a memory-mapped write with `mm_off` = 0x0B0, or a register write with `rg_idx` = 0x80B. The write data is ignored.
- R3: A self-IPI is a memory-mapped write with `mm_off` = 0x300, or a register write with `rg_idx` = 0x83F. Its vector is the 8-bit data of that write.
- R4: An end-of-interrupt clears the in-service bit at the index equal to the servicing index held before the operation.
- R5: After an end-of-interrupt, the servicing index is the index of the highest in-service bit still set, or 0 when no in-service bit remains set.
- R6: `ppr` equals `task_prio` when `task_prio[7:4]` >= `svi[7:4]`; otherwise it is `{svi[7:4], 4'h0}`. It follows the current servicing index.
- R7: If `exit_bitmap` has a 1 at the retired vector, an end-of-interrupt pulses `exit_req` with `exit_vec` equal to that vector. Otherwise it pulses `eval_req`. The two never pulse together, and `exit_vec` is 0 when `exit_req` is 0.
- R8: The exit is trap-like: `exit_req` pulses in the same cycle as `op_done`, one cycle after the accepted write. The state updated by the write is already visible in that cycle.
- R9: A self-IPI sets the request bit at its vector, sets the requesting index to the larger of its old value and the vector, and pulses `eval_req` together with `op_done` one cycle after the write.
- R10: `pend_deliverable` is 1 exactly when `rvi[7:4]` > `ppr[7:4]`.
- R11: At most one operation is accepted per cycle. When `mm_valid` and `rg_valid` are both 1, the memory-mapped write is decoded and the register write is dropped.
- R12: After reset, both 256-bit vectors and both indices are 0, and `op_done`, `exit_req` and `eval_req` are 0.
- R13: `load_valid` replaces the in-service vector, request vector, servicing index and requesting index on the next cycle, whatever the value of `vid_en`. Any operation in the same cycle is dropped and no done pulse follows.
- R14: Writes to any other offset or index are ignored: no pulse and no change of state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vid_en | input | 1 | Virtual interrupt delivery enable |
| mm_valid | input | 1 | Memory-mapped write strobe |
| mm_off | input | 12 | Page offset of the memory-mapped write |
| mm_data | input | 8 | Data of the memory-mapped write (self-IPI vector) |
| rg_valid | input | 1 | Register write strobe |
| rg_idx | input | 12 | Register index of the register write |
| rg_data | input | 8 | Data of the register write (self-IPI vector) |
| task_prio | input | 8 | Virtual task priority |
| exit_bitmap | input | 256 | Per-vector end-of-interrupt exit selection |
| load_valid | input | 1 | Install a new interrupt state |
| load_isr | input | 256 | In-service vector to install |
| load_irr | input | 256 | Request vector to install |
| load_svi | input | 8 | Servicing index to install |
| load_rvi | input | 8 | Requesting index to install |
| isr | output | 256 | In-service vector |
| irr | output | 256 | Request vector |
| svi | output | 8 | Servicing index |
| rvi | output | 8 | Requesting index |
| ppr | output | 8 | Processor priority |
| pend_deliverable | output | 1 | A requested interrupt outranks the processor priority |
| op_done | output | 1 | One-cycle pulse: an operation completed |
| exit_req | output | 1 | One-cycle pulse: trap-like exit after end-of-interrupt |
| exit_vec | output | 8 | Vector reported with the exit |
| eval_req | output | 1 | One-cycle pulse: evaluate pending interrupts |

## Verification
If the priority encoder is wrong, the servicing index comes out wrong on the cycle after an end-of-interrupt. It then reaches `ppr` and `pend_deliverable` at once. The next end-of-interrupt clears the wrong in-service bit and tests the wrong bitmap bit, so `exit_req` or `exit_vec` also goes wrong. A lost or misplaced request bit, or a bad maximum for the requesting index, shows on `irr` and `rvi` in the cycle after the self-IPI. Broken gating or arbitration shows as a stray `op_done` one cycle after the write, or as a changed state vector. Random traffic with loaded states and random bitmaps is compared against a bench model on every cycle.

// File: rtl/vintc_pkg.sv
package vintc_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_EOI  = 2'd1,
    OP_IPI  = 2'd2
  } op_kind_e;
endpackage

// File: rtl/vintc_op_decode.sv
module vintc_op_decode
  import vintc_pkg::*;
#(
  parameter int AW = 12,
  parameter int VW = 8,
  parameter logic [AW-1:0] MM_EOI  = 12'h0B0,
  parameter logic [AW-1:0] MM_IPI  = 12'h300,
  parameter logic [AW-1:0] RG_EOI  = 12'h80B,
  parameter logic [AW-1:0] RG_IPI  = 12'h83F
) (
  input  logic          en,
  input  logic          mm_v,
  input  logic [AW-1:0] mm_off,
  input  logic [VW-1:0] mm_dat,
  input  logic          rg_v,
  input  logic [AW-1:0] rg_idx,
  input  logic [VW-1:0] rg_dat,
  output op_kind_e      kind,
  output logic [VW-1:0] vec
);
  always_comb begin
    kind = OP_NONE;
    vec  = '0;
    if (en) begin
      if (mm_v) begin
        // memory-mapped source wins arbitration (R11)
        if (mm_off == MM_EOI) kind = OP_EOI;
        else if (mm_off == MM_IPI) begin
          kind = OP_IPI;
          vec  = mm_dat;
        end
      end else if (rg_v) begin
        if (rg_idx == RG_EOI) kind = OP_EOI;
        else if (rg_idx == RG_IPI) begin
          kind = OP_IPI;
          vec  = rg_dat;
        end
      end
    end
  end
endmodule

// File: rtl/vintc_hi_enc.sv
module vintc_hi_enc #(
  parameter int N = 256,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (vec_i[i]) begin
        idx_o = IW'(i);
        any_o = 1'b1;
      end
    end
  end

  // R5: the reported bit is set and nothing above it is
  always_comb begin
    assert_hi_bit_R5: assert (!any_o || ((vec_i >> idx_o) == ONE));
    assert_empty_zero_R5: assert (any_o || (idx_o == '0));
  end
endmodule

// File: rtl/vintc_ppr.sv
module vintc_ppr #(
  parameter int VW = 8
) (
  input  logic [VW-1:0] tpr,
  input  logic [VW-1:0] svi,
  input  logic [VW-1:0] rvi,
  output logic [VW-1:0] ppr,
  output logic          deliverable
);
  localparam int HW = VW / 2;

  always_comb begin
    if (tpr[VW-1 -: HW] >= svi[VW-1 -: HW]) ppr = tpr;
    else ppr = {svi[VW-1 -: HW], {(VW-HW){1'b0}}};
    deliverable = rvi[VW-1 -: HW] > ppr[VW-1 -: HW];
  end
endmodule

// File: rtl/vintc_eoi_ipi.sv
module vintc_eoi_ipi
  import vintc_pkg::*;
#(
  parameter int NVEC = 256,
  parameter int AW   = 12,
  localparam int VW  = $clog2(NVEC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vid_en,
  input  logic            mm_valid,
  input  logic [AW-1:0]   mm_off,
  input  logic [VW-1:0]   mm_data,
  input  logic            rg_valid,
  input  logic [AW-1:0]   rg_idx,
  input  logic [VW-1:0]   rg_data,
  input  logic [VW-1:0]   task_prio,
  input  logic [NVEC-1:0] exit_bitmap,
  input  logic            load_valid,
  input  logic [NVEC-1:0] load_isr,
  input  logic [NVEC-1:0] load_irr,
  input  logic [VW-1:0]   load_svi,
  input  logic [VW-1:0]   load_rvi,
  output logic [NVEC-1:0] isr,
  output logic [NVEC-1:0] irr,
  output logic [VW-1:0]   svi,
  output logic [VW-1:0]   rvi,
  output logic [VW-1:0]   ppr,
  output logic            pend_deliverable,
  output logic            op_done,
  output logic            exit_req,
  output logic [VW-1:0]   exit_vec,
  output logic            eval_req
);
  localparam logic [NVEC-1:0] ONE = {{(NVEC-1){1'b0}}, 1'b1};

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  op_kind_e        op_kind;
  logic [VW-1:0]   op_vec;
  logic [NVEC-1:0] isr_q, isr_n, irr_q, irr_n, isr_clr;
  logic [VW-1:0]   svi_q, svi_n, rvi_q, rvi_n, xv_q, xv_n, enc_idx;
  logic            done_q, done_n, exit_q, exit_n, eval_q, eval_n, enc_any;
  logic            st_en;

  vintc_op_decode #(.AW(AW), .VW(VW)) u_dec (
    .en(vid_en), .mm_v(mm_valid), .mm_off(mm_off), .mm_dat(mm_data),
    .rg_v(rg_valid), .rg_idx(rg_idx), .rg_dat(rg_data),
    .kind(op_kind), .vec(op_vec)
  );

  assign isr_clr = isr_q & ~(ONE << svi_q);

  vintc_hi_enc #(.N(NVEC)) u_enc (
    .vec_i(isr_clr), .idx_o(enc_idx), .any_o(enc_any)
  );

  vintc_ppr #(.VW(VW)) u_ppr (
    .tpr(task_prio), .svi(svi_q), .rvi(rvi_q),
    .ppr(ppr), .deliverable(pend_deliverable)
  );

  // next state
  always_comb begin
    isr_n  = isr_q;
    irr_n  = irr_q;
    svi_n  = svi_q;
    rvi_n  = rvi_q;
    done_n = 1'b0;
    exit_n = 1'b0;
    eval_n = 1'b0;
    xv_n   = '0;
    if (load_valid) begin
      isr_n = load_isr;
      irr_n = load_irr;
      svi_n = load_svi;
      rvi_n = load_rvi;
    end else if (op_kind == OP_EOI) begin
      isr_n  = isr_clr;
      svi_n  = enc_any ? enc_idx : '0;
      done_n = 1'b1;
      if (exit_bitmap[svi_q]) begin
        exit_n = 1'b1;
        xv_n   = svi_q;
      end else begin
        eval_n = 1'b1;
      end
    end else if (op_kind == OP_IPI) begin
      irr_n  = irr_q | (ONE << op_vec);
      rvi_n  = (op_vec > rvi_q) ? op_vec : rvi_q;
      done_n = 1'b1;
      eval_n = 1'b1;
    end
  end

  assign st_en = load_valid || (op_kind != OP_NONE);

  // state registers, written only when something is accepted
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      isr_q <= '0;
      irr_q <= '0;
      svi_q <= '0;
      rvi_q <= '0;
    end else if (st_en) begin
      isr_q <= isr_n;
      irr_q <= irr_n;
      svi_q <= svi_n;
      rvi_q <= rvi_n;
    end
  end

  // result pulses
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      done_q <= 1'b0;
      exit_q <= 1'b0;
      eval_q <= 1'b0;
      xv_q   <= '0;
    end else begin
      done_q <= done_n;
      exit_q <= exit_n;
      eval_q <= eval_n;
      xv_q   <= xv_n;
    end
  end

  assign isr      = isr_q;
  assign irr      = irr_q;
  assign svi      = svi_q;
  assign rvi      = rvi_q;
  assign op_done  = done_q;
  assign exit_req = exit_q;
  assign exit_vec = xv_q;
  assign eval_req = eval_q;

  assert_gate_R1: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!vid_en && !load_valid) |=> (!done_q && $stable(isr_q) && $stable(irr_q)
                                  && $stable(svi_q) && $stable(rvi_q)));

  assert_eoi_clear_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (op_kind == OP_EOI && !load_valid) |=> !isr_q[$past(svi_q)]);

  assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(exit_q && eval_q));

  assert_trap_done_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    exit_q |-> done_q);

  assert_ipi_post_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (op_kind == OP_IPI && !load_valid) |=>
      (irr_q[$past(op_vec)] && rvi_q >= $past(rvi_q) && rvi_q >= $past(op_vec)));

  assert_load_quiet_R13: assert property (@(posedge clk) disable iff (!rst_s_n)
    load_valid |=> !done_q);
endmodule

// File: tb/vintc_eoi_ipi_test.sv
`timescale 1ns/1ps
module vintc_eoi_ipi_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         vid_en, mm_valid, rg_valid, load_valid;
  logic [11:0]  mm_off, rg_idx;
  logic [7:0]   mm_data, rg_data, task_prio, load_svi, load_rvi;
  logic [255:0] exit_bitmap, load_isr, load_irr;
  logic [255:0] isr, irr;
  logic [7:0]   svi, rvi, ppr, exit_vec;
  logic         pend_deliverable, op_done, exit_req, eval_req;

  int total = 0;
  int fails = 0;
  bit finished = 0;

  logic [255:0] m_isr, m_irr;
  logic [7:0]   m_svi, m_rvi;

  always #4 clk = ~clk;

  vintc_eoi_ipi uut (
    .clk(clk), .rst_n(rst_n), .vid_en(vid_en),
    .mm_valid(mm_valid), .mm_off(mm_off), .mm_data(mm_data),
    .rg_valid(rg_valid), .rg_idx(rg_idx), .rg_data(rg_data),
    .task_prio(task_prio), .exit_bitmap(exit_bitmap),
    .load_valid(load_valid), .load_isr(load_isr), .load_irr(load_irr),
    .load_svi(load_svi), .load_rvi(load_rvi),
    .isr(isr), .irr(irr), .svi(svi), .rvi(rvi), .ppr(ppr),
    .pend_deliverable(pend_deliverable), .op_done(op_done),
    .exit_req(exit_req), .exit_vec(exit_vec), .eval_req(eval_req)
  );

  function automatic logic [7:0] hi_idx(logic [255:0] v);
    logic [7:0] r = 8'd0;
    for (int i = 0; i < 256; i++) if (v[i]) r = 8'(i);
    return r;
  endfunction

  function automatic logic [7:0] ppr_f(logic [7:0] t, logic [7:0] s);
    return (t[7:4] >= s[7:4]) ? t : {s[7:4], 4'h0};
  endfunction

  task automatic chk(string tag, string what, logic [255:0] act, logic [255:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    mm_valid = 0; rg_valid = 0; load_valid = 0;
    mm_off = '0; rg_idx = '0; mm_data = '0; rg_data = '0;
  endtask

  // inputs are already driven; update the model, step one cycle, compare
  task automatic apply(string tag);
    logic e_done = 0, e_exit = 0, e_eval = 0;
    logic [7:0] e_xv = 0, v;
    int kind = 0; // 0 none, 1 eoi, 2 ipi
    logic [7:0] d = 0;
    if (load_valid) begin
      m_isr = load_isr; m_irr = load_irr; m_svi = load_svi; m_rvi = load_rvi;
    end else if (vid_en) begin
      if (mm_valid) begin
        if (mm_off == 12'h0B0) kind = 1;
        else if (mm_off == 12'h300) begin kind = 2; d = mm_data; end
      end else if (rg_valid) begin
        if (rg_idx == 12'h80B) kind = 1;
        else if (rg_idx == 12'h83F) begin kind = 2; d = rg_data; end
      end
    end
    if (kind == 1) begin
      v = m_svi;
      m_isr[v] = 1'b0;
      m_svi = hi_idx(m_isr);
      e_done = 1;
      if (exit_bitmap[v]) begin e_exit = 1; e_xv = v; end
      else e_eval = 1;
    end else if (kind == 2) begin
      m_irr[d] = 1'b1;
      if (d > m_rvi) m_rvi = d;
      e_done = 1; e_eval = 1;
    end
    @(negedge clk);
    chk(tag, "op_done", 256'(op_done), 256'(e_done));
    chk(tag, "exit_req", 256'(exit_req), 256'(e_exit));
    chk(tag, "exit_vec", 256'(exit_vec), 256'(e_xv));
    chk(tag, "eval_req", 256'(eval_req), 256'(e_eval));
    chk(tag, "isr", isr, m_isr);
    chk(tag, "irr", irr, m_irr);
    chk(tag, "svi", 256'(svi), 256'(m_svi));
    chk(tag, "rvi", 256'(rvi), 256'(m_rvi));
    chk("R6", "ppr", 256'(ppr), 256'(ppr_f(task_prio, m_svi)));
    chk("R10", "pend_deliverable", 256'(pend_deliverable),
        256'(m_rvi[7:4] > ppr_f(task_prio, m_svi)[7:4]));
    idle_inputs();
  endtask

  task automatic do_load(logic [255:0] i, logic [255:0] r, logic [7:0] s, logic [7:0] q);
    load_valid = 1; load_isr = i; load_irr = r; load_svi = s; load_rvi = q;
    apply("R13");
  endtask

  task automatic mm_wr(logic [11:0] o, logic [7:0] dd, string tag);
    mm_valid = 1; mm_off = o; mm_data = dd; apply(tag);
  endtask

  task automatic rg_wr(logic [11:0] o, logic [7:0] dd, string tag);
    rg_valid = 1; rg_idx = o; rg_data = dd; apply(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog R12 act=hung exp=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [255:0] ti, tr;
    void'($urandom(32'd20240611));
    rst_n = 0; vid_en = 1; task_prio = 8'h30;
    exit_bitmap = '0; load_isr = '0; load_irr = '0; load_svi = 0; load_rvi = 0;
    idle_inputs();
    m_isr = '0; m_irr = '0; m_svi = 0; m_rvi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R12 reset state
    chk("R12", "isr", isr, '0);
    chk("R12", "irr", irr, '0);
    chk("R12", "svi/rvi", 256'({svi, rvi}), '0);
    chk("R12", "pulses", 256'({op_done, exit_req, eval_req}), '0);

    // install three in-service vectors
    ti = '0; ti[8'h45] = 1; ti[8'h31] = 1; ti[8'h10] = 1;
    do_load(ti, '0, 8'h45, 8'h20);
    chk("R6", "ppr from svi", 256'(ppr), 256'(8'h40));
    task_prio = 8'h4F;
    @(negedge clk);
    chk("R6", "ppr equal nibble", 256'(ppr), 256'(8'h4F));
    task_prio = 8'h30;

    mm_wr(12'h0B0, 8'h00, "R2 R4 R5 mm eoi");     // retires 0x45 -> svi 0x31
    exit_bitmap[8'h31] = 1;
    rg_wr(12'h80B, 8'hAA, "R7 R8 rg eoi exit");   // exit with 0x31 -> svi 0x10
    exit_bitmap = '0;
    mm_wr(12'h0B0, 8'h00, "R5 last eoi");         // svi 0
    mm_wr(12'h0B0, 8'h00, "R5 empty eoi");

    do_load(ti, '0, 8'h45, 8'h00);
    vid_en = 0;
    mm_wr(12'h0B0, 8'h00, "R1 disabled mm eoi");
    rg_wr(12'h83F, 8'h77, "R1 disabled rg ipi");
    vid_en = 1;

    mm_wr(12'h300, 8'h50, "R3 R9 mm ipi");
    rg_wr(12'h83F, 8'h12, "R3 R9 rg ipi lower");
    rg_wr(12'h83F, 8'hF0, "R9 R10 rg ipi high");

    mm_valid = 1; mm_off = 12'h300; mm_data = 8'h60;
    rg_valid = 1; rg_idx = 12'h80B;
    apply("R11 both sources");
    mm_valid = 1; mm_off = 12'h0B4;
    rg_valid = 1; rg_idx = 12'h80B;
    apply("R11 mm wins even if bad");

    mm_wr(12'h0B4, 8'h00, "R14 bad offset");
    rg_wr(12'h80C, 8'h22, "R14 bad index");
    mm_wr(12'h830, 8'h22, "R14 reg index on mm");

    load_valid = 1; load_isr = '0; load_irr = '0; load_svi = 0; load_rvi = 0;
    mm_valid = 1; mm_off = 12'h300; mm_data = 8'h99;
    apply("R13 load beats op");

    // random traffic
    for (int it = 0; it < 600; it++) begin
      int sel = int'($urandom % 10);
      task_prio = 8'($urandom);
      for (int w = 0; w < 8; w++) exit_bitmap[w*32 +: 32] = $urandom;
      vid_en = ($urandom % 8) != 0;
      if (sel == 0) begin
        ti = '0; tr = '0;
        for (int k = 0; k < 5; k++) begin
          ti[8'($urandom)] = 1'b1;
          tr[8'($urandom)] = 1'b1;
        end
        do_load(ti, tr, hi_idx(ti), hi_idx(tr));
      end else if (sel < 4) begin
        mm_wr(12'h0B0, 8'($urandom), "R4 R5 R7 rand mm eoi");
      end else if (sel < 6) begin
        rg_wr(12'h80B, 8'($urandom), "R4 R5 R7 rand rg eoi");
      end else if (sel == 6) begin
        mm_wr(12'h300, 8'($urandom), "R9 rand mm ipi");
      end else if (sel == 7) begin
        rg_wr(12'h83F, 8'($urandom), "R9 rand rg ipi");
      end else if (sel == 8) begin
        mm_valid = 1; mm_off = ($urandom % 2) ? 12'h300 : 12'h0B0;
        mm_data = 8'($urandom);
        rg_valid = 1; rg_idx = ($urandom % 2) ? 12'h83F : 12'h80B;
        rg_data = 8'($urandom);
        apply("R11 rand both");
      end else begin
        rg_wr(12'($urandom), 8'($urandom), "R14 rand index");
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule